// File: doc/BRIEF.md
# Synchronous Burst Memory Control Front End

This block is the control path and storage of a flow-through synchronous burst memory. It sits on a processor bus with two independent address strobes: a processor-side strobe and a cache-controller-side strobe. When either strobe is asserted, the block captures a start address and the chip-select state on the rising clock edge. An internal 2-bit beat counter then produces the low address bits for the remaining beats of a 4-beat burst. The counter moves only when the advance input is asserted.

A static order pin selects the burst order. In interleaved order the beat count is XORed into the low bits. In linear order the low bits are incremented modulo four. Read data comes straight from the array for the address currently held, with no output register, so a burst runs 2-1-1-1. Data travels on one bidirectional bus. The block drives that bus only while the output enable is low and the device is selected, and the output enable takes effect without a clock edge.

Writes are synchronous. A global write enable writes every byte lane. Otherwise, a byte-write enable together with per-lane enables writes only the chosen lanes. The data is taken from the bus on the same edge that fixes the target address.

Top module: `sburst_mem`

## Requirements
- R1: After a synchronous reset the device is deselected, so the data bus is released even while the output enable is low.
- R2: The address is captured only on an edge where the controller strobe is low, or the processor strobe is low while the first select `sel_a_n` is low. On other edges, a change on the address pins has no effect.
- R3: When both strobes are low on the same edge, the controller strobe wins. Any write requested on that edge is performed.
- R4: A low processor strobe is ignored while `sel_a_n` is high. With the advance input high, the held address does not change.
- R5: With `order_ilv` = 1, beat k of a burst that starts at low bits s addresses low bits s XOR k, for every s from 0 to 3.
- R6: With `order_ilv` = 0, beat k of a burst that starts at low bits s addresses low bits (s + k) mod 4, for every s from 0 to 3.
- R7: On an edge with no strobe and `adv_n` high, the burst address is held.
- R8: The beat counter wraps inside its aligned 4-word block. The upper address bits never change during a burst.
- R9: Read data for a newly captured address appears on the bus in the cycle that follows the capturing edge, with no extra register stage.
- R10: Raising `oe_n` releases the bus at once, without waiting for a clock edge. Lowering it again restores the data.
- R11: With `wr_all_n` low, all four 9-bit lanes of the target word are written. Lane i occupies bits 9i+8 to 9i.
- R12: With `wr_all_n` high and `wr_bytes_n` low, only the lanes whose `lane_n[i]` is low are written. With both write enables high, nothing is written.
- R13: Write enables are ignored on an edge that captures an address through the processor strobe. A write on a later edge of the same burst is committed.
- R14: An address captured while any select is inactive (`sel_a_n` high, `sel_b` low or `sel_c_n` high) deselects the device. The bus is then released and writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address, captured on a strobe edge |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low, has priority |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Select, active low; also gates the processor strobe |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| wr_all_n | input | 1 | Global write enable, active low |
| wr_bytes_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | DATA_W | Shared data bus |

## Verification
The embedded assertions check the following on every cycle:
- a captured address equals the pins sampled at the strobe edge;
- the address holds when there is neither a strobe nor an advance;
- the upper bits never move between strobes;
- a gated processor strobe leaves the address alone;
- no lane is written on a processor-strobe capture edge;
- a deselecting capture clears the selected state.

Other properties need data through the array, so only the bench scenarios can show them:
- the exact beat order for each start offset in both orders;
- the lane contents after partial and dropped writes;
- the winner when both strobes are low;
- the immediate release of the bus by the output enable.

// File: rtl/sburst_pkg.sv
`timescale 1ns/1ps
// Shared types and the burst-order helper for the burst memory front end.
// Assumes a 2-bit beat counter, so a burst is always 4 beats.
package sburst_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    localparam int BEAT_W = 2;

    // Low address bits for a beat, given the first offset and the order.
    function automatic logic [BEAT_W-1:0] beat_lsb(
        input logic [BEAT_W-1:0] first,
        input logic [BEAT_W-1:0] beat,
        input order_e            ord
    );
        return (ord == ORD_INTERLEAVE) ? (first ^ beat) : (first + beat);
    endfunction

endpackage

// File: rtl/sburst_ctr.sv
`timescale 1ns/1ps
// Burst address generator.
// Holds the aligned upper address, the first offset and a 2-bit beat count.
// cur_addr is the address in effect in this cycle (used for reads).
// nxt_addr is the address that becomes current after the coming edge; it is
// used as the write target on that edge.
// Assumes ADDR_W > 2, that load and adv are never both acted on (load wins),
// and that order is a static strap.
module sburst_ctr
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  order_e            order,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr
);
    localparam int UP_W = ADDR_W - BEAT_W;

    logic [UP_W-1:0]   upper_q;
    logic [BEAT_W-1:0] first_q;
    logic [BEAT_W-1:0] beat_q;

    // Capture a new start address on load, otherwise step the beat on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            first_q <= '0;
            beat_q  <= '0;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:BEAT_W];
            first_q <= addr_in[BEAT_W-1:0];
            beat_q  <= '0;
        end else if (adv) begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    // Form the current and the next-edge addresses from the counter state.
    always_comb begin
        cur_addr = {upper_q, beat_lsb(first_q, beat_q, order)};
        if (load)
            nxt_addr = addr_in;
        else if (adv)
            nxt_addr = {upper_q, beat_lsb(first_q, beat_q + 1'b1, order)};
        else
            nxt_addr = cur_addr;
    end

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_addr == $past(addr_in)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(cur_addr));

    // R8
    upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));

endmodule

// File: rtl/sburst_wdec.sv
`timescale 1ns/1ps
// Write-enable decoder.
// The global enable selects every lane. Otherwise the byte-write enable
// passes the per-lane enables through. Nothing is enabled unless allow is
// high, meaning the device is selected and the edge is not a
// processor-strobe capture.
module sburst_wdec #(
    parameter int LANES = 4
) (
    input  logic             allow,
    input  logic             all_n,
    input  logic             bytes_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_we
);
    // Build the per-lane write strobes.
    always_comb begin
        if (!allow)
            lane_we = '0;
        else if (!all_n)
            lane_we = '1;
        else if (!bytes_n)
            lane_we = ~lane_n;
        else
            lane_we = '0;
    end
endmodule

// File: rtl/sburst_array.sv
`timescale 1ns/1ps
// Storage array, split into independently written byte lanes.
// Writes happen on the clock edge. The read port is combinational
// (flow-through). Contents are not reset.
module sburst_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Commit this lane's slice when its strobe is set.
        always_ff @(posedge clk) begin
            if (lane_we[g])
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        // Read this lane's slice without a register stage.
        always_comb rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/sburst_mem.sv
`timescale 1ns/1ps
// Flow-through synchronous burst memory front end (top).
// Arbitrates the two address strobes (controller first), tracks the
// selected state, drives the burst counter, decodes write enables and
// drives the shared bus under the asynchronous output enable.
// Assumes the user keeps oe_n high on write cycles, so that the bus
// carries the write data.
module sburst_mem
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              adv_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              order_ilv,
    input  logic              wr_all_n,
    input  logic              wr_bytes_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic              oe_n,
    inout  wire  [DATA_W-1:0] dq
);
    logic              load_ctrl, load_proc, load, adv;
    logic              chip_ok, selected, sel_next, allow;
    logic [ADDR_W-1:0] cur_addr, nxt_addr;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] rdata;

    // Strobe arbitration: the controller strobe wins; the processor strobe needs sel_a_n.
    always_comb begin
        load_ctrl = !ctrl_strobe_n;
        load_proc = !proc_strobe_n && !sel_a_n && ctrl_strobe_n;
        load      = load_ctrl || load_proc;
        adv       = !adv_n && !load;
        chip_ok   = !sel_a_n && sel_b && !sel_c_n;
        sel_next  = load ? chip_ok : selected;
        allow     = sel_next && !load_proc;
    end

    // Selected state, updated on every capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            selected <= 1'b0;
        else if (load)
            selected <= chip_ok;
    end

    sburst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .order    (order_e'(order_ilv)),
        .addr_in  (addr),
        .cur_addr (cur_addr),
        .nxt_addr (nxt_addr)
    );

    sburst_wdec #(.LANES(LANES)) u_wdec (
        .allow   (allow),
        .all_n   (wr_all_n),
        .bytes_n (wr_bytes_n),
        .lane_n  (lane_n),
        .lane_we (lane_we)
    );

    sburst_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .lane_we (lane_we),
        .waddr   (nxt_addr),
        .wdata   (dq),
        .raddr   (cur_addr),
        .rdata   (rdata)
    );

    // Bus driver, gated asynchronously by the output enable.
    assign dq = (!oe_n && selected) ? rdata : {DATA_W{1'bz}};

    // R4
    ignore_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && sel_a_n && ctrl_strobe_n && adv_n) |=> $stable(cur_addr));

    // R13
    first_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && ctrl_strobe_n && !sel_a_n) |-> (lane_we == '0));

    // R14
    desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_strobe_n && !sel_b) |=> !selected);

endmodule

// File: tb/sburst_mem_bench.sv
`timescale 1ns/1ps
module sburst_mem_bench;
    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam logic [DW-1:0] ONES = '1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          proc_n = 1'b1, ctrl_n = 1'b1, adv_n = 1'b1;
    logic          sa_n = 1'b0, sb = 1'b1, sc_n = 1'b0, ilv = 1'b0;
    logic          all_n = 1'b1, bytes_n = 1'b1, oe_n = 1'b0;
    logic [NL-1:0] lane_n = '1;
    logic          drv_en = 1'b0;
    logic [DW-1:0] drv_val = '0;
    wire  [DW-1:0] dq;

    assign dq = drv_en ? drv_val : {DW{1'bz}};
    for (genvar i = 0; i < DW; i++) begin : g_pu
        pullup (dq[i]);
    end

    sburst_mem u_sburst_mem (
        .clk(clk), .rst_n(rst_n), .addr(addr), .proc_strobe_n(proc_n),
        .ctrl_strobe_n(ctrl_n), .adv_n(adv_n), .sel_a_n(sa_n), .sel_b(sb),
        .sel_c_n(sc_n), .order_ilv(ilv), .wr_all_n(all_n), .wr_bytes_n(bytes_n),
        .lane_n(lane_n), .oe_n(oe_n), .dq(dq)
    );

    int    errors = 0, checks = 0;
    string tag = "R1";

    // Behavioural reference state.
    bit   m_sel = 0;
    int   m_base = 0, m_first = 0, m_beat = 0;
    logic [LW-1:0] m_lane [int];

    function automatic int m_cur();
        int lo = ilv ? (m_first ^ m_beat) : ((m_first + m_beat) % 4);
        return (m_base / 4) * 4 + lo;
    endfunction

    function automatic logic [DW-1:0] pat(int a);
        logic [LW-1:0] b = LW'(a);
        return {b + 9'h080, b + 9'h040, b + 9'h020, b + 9'h010};
    endfunction

    task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Apply one rising edge to the reference model.
    task automatic model_edge();
        bit lc, lp;
        int tgt;
        if (!rst_n) begin
            m_sel = 0; m_base = 0; m_first = 0; m_beat = 0;
            return;
        end
        lc = !ctrl_n;
        lp = !proc_n && !sa_n && !lc;
        if (lc || lp) begin
            m_sel = !sa_n && sb && !sc_n;
            m_base = int'(addr); m_first = int'(addr) % 4; m_beat = 0;
        end else if (!adv_n) begin
            m_beat = (m_beat + 1) % 4;
        end
        tgt = m_cur();
        if (m_sel && !lp)
            for (int l = 0; l < NL; l++)
                if (!all_n || (!bytes_n && !lane_n[l]))
                    m_lane[tgt*NL + l] = drv_val[l*LW +: LW];
    endtask

    function automatic bit m_expect(output logic [DW-1:0] e);
        int c = m_cur();
        if (drv_en) return 0;
        if (oe_n || !m_sel) begin e = ONES; return 1; end
        for (int l = 0; l < NL; l++) begin
            if (!m_lane.exists(c*NL + l)) return 0;
            e[l*LW +: LW] = m_lane[c*NL + l];
        end
        return 1;
    endfunction

    // One clock: model update at the edge, comparison at the falling edge.
    task automatic step();
        logic [DW-1:0] e;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (m_expect(e)) chk(tag, dq, e);
    endtask

    task automatic idle();
        proc_n = 1; ctrl_n = 1; adv_n = 1; all_n = 1; bytes_n = 1;
        lane_n = '1; drv_en = 0; oe_n = 0;
    endtask

    task automatic ctrl_write(int a, logic [DW-1:0] v);
        idle(); ctrl_n = 0; addr = AW'(a); all_n = 0; oe_n = 1; drv_en = 1; drv_val = v;
        step();
    endtask

    task automatic ctrl_read(int a);
        idle(); ctrl_n = 0; addr = AW'(a);
        step();
    endtask

    // 4-beat read burst via the processor strobe, checked explicitly per beat.
    task automatic burst(int a, bit il);
        int s = a % 4, lo;
        ilv = il;
        idle(); proc_n = 0; addr = AW'(a);
        step();
        chk(il ? "R5 beat0 R9" : "R6 beat0 R9", dq, pat(a));
        for (int k = 1; k < 4; k++) begin
            idle(); adv_n = 0;
            step();
            lo = il ? (s ^ k) : ((s + k) % 4);
            chk(il ? "R5 R8" : "R6 R8", dq, pat((a / 4) * 4 + lo));
        end
        idle(); adv_n = 0;
        step();
        chk("R8 wrap", dq, pat(a));
    endtask

    bit done = 0;
    initial begin
        #800000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        @(negedge clk);
        repeat (3) step();
        rst_n = 1;
        tag = "R1";
        step();
        chk("R1", dq, ONES);

        tag = "R11";
        for (int a = 0; a < 16; a++) ctrl_write(a, pat(a));
        ctrl_read(2);
        chk("R11", dq, pat(2));

        for (int s = 0; s < 4; s++) begin
            tag = "R5"; burst(8 + s, 1'b1);
            tag = "R6"; burst(4 + s, 1'b0);
        end

        tag = "R7";
        ilv = 0; ctrl_read(13);
        idle(); adv_n = 0; step();
        idle(); step(); step();
        chk("R7", dq, pat(14));

        tag = "R2";
        idle(); addr = 6'd1; step();
        chk("R2", dq, pat(14));

        tag = "R4";
        idle(); proc_n = 0; sa_n = 1; addr = 6'd3; step();
        sa_n = 0;
        chk("R4", dq, pat(14));

        tag = "R12";
        idle(); ctrl_n = 0; addr = 6'd6; bytes_n = 0; lane_n = 4'b1010;
        oe_n = 1; drv_en = 1; drv_val = '0; step();
        ctrl_read(6);
        v = pat(6) & ~{9'h0, 9'h1FF, 9'h0, 9'h1FF};
        chk("R12 lanes", dq, v);
        idle(); ctrl_n = 0; addr = 6'd7; lane_n = 4'b0000;
        oe_n = 1; drv_en = 1; drv_val = '0; step();
        ctrl_read(7);
        chk("R12 none", dq, pat(7));

        tag = "R13";
        idle(); proc_n = 0; addr = 6'd5; all_n = 0; oe_n = 1; drv_en = 1;
        drv_val = 36'h5_A5A5_A5A5; step();
        idle(); step();
        chk("R13 ignored", dq, pat(5));
        idle(); all_n = 0; oe_n = 1; drv_en = 1; drv_val = 36'h5_A5A5_A5A5; step();
        idle(); step();
        chk("R13 later", dq, 36'h5_A5A5_A5A5);

        tag = "R3";
        idle(); ctrl_n = 0; proc_n = 0; addr = 6'd9; all_n = 0; oe_n = 1;
        drv_en = 1; drv_val = 36'h3_0C30_C30C; step();
        ctrl_read(9);
        chk("R3", dq, 36'h3_0C30_C30C);

        tag = "R14";
        idle(); ctrl_n = 0; sb = 0; addr = 6'd3; all_n = 0; oe_n = 1;
        drv_en = 1; drv_val = '0; step();
        idle(); step();
        chk("R14 released", dq, ONES);
        sb = 1;
        ctrl_read(3);
        chk("R14 dropped", dq, pat(3));

        tag = "R10";
        idle(); ctrl_read(10);
        #1 oe_n = 1;
        #1 chk("R10 off", dq, ONES);
        oe_n = 0;
        #0.5 chk("R10 on", dq, pat(10));
        idle(); step();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule